// File: doc/BRIEF.md
# ADC Power Mode Controller

This block decides how a two-converter ADC spends power between scans. From the per-converter power-down bits, the auto-powerdown enable, the auto-standby enable and the clock-gate enable, it works out the current power mode. It then drives two outputs: a select line that picks the fast conversion clock or the slow idle clock, and a flag that marks the low-current standby state.

A scan request is not passed straight to the converters. The controller grants it with a one-cycle pulse once the analog side is ready. In normal mode the grant follows immediately. In the two automatic low-power modes, the controller first switches back to the conversion clock and to normal current. It then waits a programmable number of ADC clocks and only then grants. The conversion clock stays engaged until the scan-done indication arrives. After that the block falls back to its idle settings.

Top module: `adcpm_ctrl`

## Requirements
- R1: `pwr_mode` is registered and uses this encoding: 2'b00 off, 2'b01 normal, 2'b10 auto-standby, 2'b11 auto-powerdown. Off applies when every converter is powered down or the clock gate is 0. Otherwise, auto-powerdown takes priority over auto-standby, and auto-standby takes priority over normal.
- R2: In normal mode `fast_clk_sel` is 1 whether the block is idle or active. A request sampled in idle is granted on the next clock, with no startup delay.
- R3: In auto-standby or auto-powerdown mode, while no scan is pending or running and `scan_busy` is 0, the block selects the slow clock (`fast_clk_sel`=0) and reports `low_current`=1. `low_current` is always the inverse of `fast_clk_sel`. After reset, `pwr_mode` is 2'b00, `fast_clk_sel` is 0, `low_current` is 1 and `scan_grant` is 0.
- R4: Take a low-power mode with `wake_cycles`=N>0. If a request is sampled in idle at clock edge k, the grant is visible after edge k+N. Throughout the delay, `fast_clk_sel` is 1 and `low_current` is 0.
- R5: A `wake_cycles` value of 0 grants on the next clock in the low-power modes as well.
- R6: A request is held from the moment it is accepted, so dropping `scan_req` during the delay does not cancel it. Each accepted request produces exactly one grant. Requests seen during the delay or during a scan are ignored.
- R7: `scan_grant` is a one-cycle pulse. The conversion clock remains selected from the grant until `scan_done` is sampled. The idle outputs for the current mode return one clock later.
- R8: In the off mode no grant is ever issued and requests are dropped. Entering the off mode during the delay or a scan abandons it, and no grant follows later.
- R9: While `scan_busy` is sampled 1 and the mode is not off, `fast_clk_sel` is 1 on the following cycle, even when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_pd | input | NUM_CONV | Per-converter power-down bits, 1 = powered down |
| auto_pd_en | input | 1 | Auto-powerdown enable |
| auto_sb_en | input | 1 | Auto-standby enable |
| clk_gate_en | input | 1 | ADC clock gate enable |
| wake_cycles | input | DLY_W | Startup delay in ADC clocks |
| scan_req | input | 1 | Scan start request |
| scan_busy | input | 1 | A scan is in progress |
| scan_done | input | 1 | The granted scan has completed |
| fast_clk_sel | output | 1 | 1 = conversion clock, 0 = slow idle clock |
| low_current | output | 1 | 1 = standby low-current state |
| pwr_mode | output | 2 | Decoded power mode (encoding in R1) |
| scan_grant | output | 1 | One-cycle scan start grant |

## Verification
The bench builds the block with NUM_CONV=2 and DLY_W=4. The 4-bit delay means the longest delay, 15, and the zero delay both come up often during random traffic. Two converters are enough to reach the all-powered-down off case as well as the partly powered cases. A behavioural model is compared against the outputs on every clock. Directed passes then measure the exact grant latency in each mode, show that a held request gives only one grant, and check that a mode change to off partway through a delay abandons it.

// File: rtl/adcpm_pkg.sv
package adcpm_pkg;
  typedef enum logic [1:0] {
    PM_OFF     = 2'b00,
    PM_NORMAL  = 2'b01,
    PM_STANDBY = 2'b10,
    PM_PWRDN   = 2'b11
  } pm_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_WAKE = 2'b01,
    SQ_RUN  = 2'b10
  } sq_state_e;
endpackage

// File: rtl/adcpm_mode_dec.sv
module adcpm_mode_dec
  import adcpm_pkg::*;
#(
  parameter int NUM_CONV = 2
) (
  input  logic [NUM_CONV-1:0] conv_pd,
  input  logic                auto_pd_en,
  input  logic                auto_sb_en,
  input  logic                clk_gate_en,
  output pm_mode_e            mode
);
  // chain of "some converter is up" flags, one stage per converter
  logic [NUM_CONV:0] up_chain;
  assign up_chain[0] = 1'b0;

  generate
    for (genvar i = 0; i < NUM_CONV; i++) begin : g_up
      assign up_chain[i+1] = up_chain[i] | ~conv_pd[i];
    end
  endgenerate

  always_comb begin
    if (!up_chain[NUM_CONV] || !clk_gate_en) mode = PM_OFF;
    else if (auto_pd_en)                     mode = PM_PWRDN;
    else if (auto_sb_en)                     mode = PM_STANDBY;
    else                                     mode = PM_NORMAL;
  end
endmodule

// File: rtl/adcpm_wake_timer.sv
module adcpm_wake_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             expired
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R4: without a load, a nonzero count steps down by exactly one per clock
  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && $past(cnt) != '0) |-> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/adcpm_ctrl.sv
module adcpm_ctrl
  import adcpm_pkg::*;
#(
  parameter int NUM_CONV = 2,
  parameter int DLY_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CONV-1:0] conv_pd,
  input  logic                auto_pd_en,
  input  logic                auto_sb_en,
  input  logic                clk_gate_en,
  input  logic [DLY_W-1:0]    wake_cycles,
  input  logic                scan_req,
  input  logic                scan_busy,
  input  logic                scan_done,
  output logic                fast_clk_sel,
  output logic                low_current,
  output logic [1:0]          pwr_mode,
  output logic                scan_grant
);
  pm_mode_e  mode;
  sq_state_e state, state_nx;
  logic      grant_nx, tmr_load, tmr_expired, fast_nx;
  logic      fast_q, grant_q;
  pm_mode_e  mode_q;

  adcpm_mode_dec #(.NUM_CONV(NUM_CONV)) u_dec (
    .conv_pd    (conv_pd),
    .auto_pd_en (auto_pd_en),
    .auto_sb_en (auto_sb_en),
    .clk_gate_en(clk_gate_en),
    .mode       (mode)
  );

  adcpm_wake_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(wake_cycles - 1'b1),
    .expired (tmr_expired)
  );

  always_comb begin
    state_nx = state;
    grant_nx = 1'b0;
    tmr_load = 1'b0;
    unique case (state)
      SQ_IDLE: begin
        if (mode != PM_OFF && scan_req) begin
          if (mode == PM_NORMAL || wake_cycles == '0) begin
            state_nx = SQ_RUN;
            grant_nx = 1'b1;
          end else begin
            state_nx = SQ_WAKE;
            tmr_load = 1'b1;
          end
        end
      end
      SQ_WAKE: begin
        if (mode == PM_OFF) state_nx = SQ_IDLE;
        else if (tmr_expired) begin
          state_nx = SQ_RUN;
          grant_nx = 1'b1;
        end
      end
      SQ_RUN: begin
        if (mode == PM_OFF || scan_done) state_nx = SQ_IDLE;
      end
      default: state_nx = SQ_IDLE;
    endcase
  end

  assign fast_nx = (mode != PM_OFF) &&
                   (mode == PM_NORMAL || state_nx != SQ_IDLE || scan_busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      fast_q  <= 1'b0;
      grant_q <= 1'b0;
      mode_q  <= PM_OFF;
    end else begin
      state   <= state_nx;
      fast_q  <= fast_nx;
      grant_q <= grant_nx;
      mode_q  <= mode;
    end
  end

  assign fast_clk_sel = fast_q;
  assign low_current  = ~fast_q;
  assign scan_grant   = grant_q;
  assign pwr_mode     = mode_q;

  // R7: the grant never lasts longer than one cycle
  p_grant_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    scan_grant |=> !scan_grant);

  // R8: no grant is ever reported in the off mode
  p_no_grant_off_r8: assert property (@(posedge clk) disable iff (rst)
    !(scan_grant && pwr_mode == PM_OFF));

  // R2: the normal mode always runs on the conversion clock
  p_normal_fast_r2: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode == PM_NORMAL) |-> fast_clk_sel);

  // R4: a grant is only issued at normal current on the conversion clock
  p_grant_fast_r4: assert property (@(posedge clk) disable iff (rst)
    scan_grant |-> (fast_clk_sel && !low_current));

  // R6: the delay is only ever entered from idle because of a request
  p_wake_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_WAKE && $past(state) == SQ_IDLE) |-> $past(scan_req));
endmodule

// File: tb/adcpm_ctrl_tb.sv
module adcpm_ctrl_tb;
  localparam int NC = 2;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] conv_pd = '0;
  logic          auto_pd_en = 1'b0, auto_sb_en = 1'b0, clk_gate_en = 1'b1;
  logic [DW-1:0] wake_cycles = '0;
  logic          scan_req = 1'b0, scan_busy = 1'b0, scan_done = 1'b0;
  logic          fast_clk_sel, low_current, scan_grant;
  logic [1:0]    pwr_mode;

  adcpm_ctrl #(.NUM_CONV(NC), .DLY_W(DW)) u_dut (
    .clk(clk), .rst(rst), .conv_pd(conv_pd), .auto_pd_en(auto_pd_en),
    .auto_sb_en(auto_sb_en), .clk_gate_en(clk_gate_en),
    .wake_cycles(wake_cycles), .scan_req(scan_req), .scan_busy(scan_busy),
    .scan_done(scan_done), .fast_clk_sel(fast_clk_sel),
    .low_current(low_current), .pwr_mode(pwr_mode), .scan_grant(scan_grant)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, grant_cnt = 0, last_grant = -1;
  int m_state = 0, m_cnt = 0, m_mode = 0;
  bit m_fast = 0, m_grant = 0;

  function automatic void chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endfunction

  function automatic int mode_of();
    if (conv_pd == {NC{1'b1}} || !clk_gate_en) return 0;
    if (auto_pd_en) return 3;
    if (auto_sb_en) return 2;
    return 1;
  endfunction

  // reference model, then comparison shortly after each edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_state = 0; m_cnt = 0; m_mode = 0; m_fast = 0; m_grant = 0;
    end else begin
      int md;
      md = mode_of();
      m_grant = 0;
      case (m_state)
        0: if (md != 0 && scan_req) begin
             if (md == 1 || wake_cycles == 0) begin m_grant = 1; m_state = 2; end
             else begin m_state = 1; m_cnt = int'(wake_cycles) - 1; end
           end
        1: if (md == 0) m_state = 0;
           else if (m_cnt == 0) begin m_grant = 1; m_state = 2; end
           else m_cnt--;
        default: if (md == 0 || scan_done) m_state = 0;
      endcase
      m_mode = md;
      m_fast = (md != 0) && (md == 1 || m_state != 0 || scan_busy);
    end
    #2;
    if (scan_grant) begin grant_cnt++; last_grant = cyc; end
    chk(pwr_mode == 2'(m_mode), "R1 mode", pwr_mode, m_mode);
    chk(fast_clk_sel == m_fast, "R3 clock select", fast_clk_sel, m_fast);
    chk(low_current == !m_fast, "R3 low current", low_current, !m_fast);
    chk(scan_grant == m_grant, "R6 grant", scan_grant, m_grant);
  end

  task automatic set_mode(int m);
    @(negedge clk);
    conv_pd = (m == 0) ? {NC{1'b1}} : '0;
    clk_gate_en = 1'b1;
    auto_pd_en = (m == 3);
    auto_sb_en = (m == 2);
    repeat (2) @(negedge clk);
  endtask

  task automatic request(int hold, output int n);
    @(negedge clk);
    scan_req = 1'b1;
    n = cyc;
    repeat (hold) @(negedge clk);
    scan_req = 1'b0;
  endtask

  task automatic finish_scan();
    @(negedge clk); scan_done = 1'b1;
    @(negedge clk); scan_done = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n, g0;
    repeat (3) @(negedge clk);
    chk(pwr_mode == 2'b00 && !fast_clk_sel && low_current && !scan_grant,
        "R3 reset state", {pwr_mode, fast_clk_sel, low_current, scan_grant}, 5'b00010);
    rst = 1'b0;

    // R2: normal mode
    set_mode(1);
    chk(fast_clk_sel, "R2 idle fast clock in normal", fast_clk_sel, 1);
    wake_cycles = 4'd9;
    request(1, n);
    repeat (3) @(negedge clk);
    chk(last_grant == n + 1, "R2 normal grant latency", last_grant - n, 1);
    finish_scan();

    // R3/R4/R6/R7: auto-standby with a delay of 5
    set_mode(2);
    wake_cycles = 4'd5;
    @(negedge clk);
    chk(!fast_clk_sel && low_current, "R3 standby idle", fast_clk_sel, 0);
    g0 = grant_cnt;
    request(3, n);
    chk(fast_clk_sel && !low_current, "R4 wake at normal current", fast_clk_sel, 1);
    repeat (6) @(negedge clk);
    chk(last_grant == n + 6, "R4 delay latency", last_grant - n, 6);
    chk(grant_cnt == g0 + 1, "R6 single grant", grant_cnt - g0, 1);
    chk(fast_clk_sel, "R7 clock held until done", fast_clk_sel, 1);
    finish_scan();
    @(negedge clk);
    chk(!fast_clk_sel && low_current, "R7 idle after done", fast_clk_sel, 0);

    // R5: auto-powerdown with zero delay
    set_mode(3);
    wake_cycles = 4'd0;
    request(1, n);
    repeat (2) @(negedge clk);
    chk(last_grant == n + 1, "R5 zero delay latency", last_grant - n, 1);
    finish_scan();

    // R8: off mode and abort
    set_mode(0);
    g0 = grant_cnt;
    request(2, n);
    repeat (20) @(negedge clk);
    chk(grant_cnt == g0, "R8 no grant when off", grant_cnt - g0, 0);
    set_mode(2);
    wake_cycles = 4'd10;
    request(1, n);
    repeat (3) @(negedge clk);
    clk_gate_en = 1'b0;
    repeat (3) @(negedge clk);
    clk_gate_en = 1'b1;
    repeat (15) @(negedge clk);
    chk(grant_cnt == g0, "R8 aborted delay never grants", grant_cnt - g0, 0);

    // R9: busy keeps the conversion clock
    @(negedge clk); scan_busy = 1'b1;
    @(negedge clk);
    chk(fast_clk_sel, "R9 busy fast clock", fast_clk_sel, 1);
    scan_busy = 1'b0;
    @(negedge clk);
    chk(!fast_clk_sel, "R9 clock released", fast_clk_sel, 0);

    // random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 99) < 4) begin
        conv_pd     = NC'($urandom);
        auto_pd_en  = $urandom_range(0, 1) == 1;
        auto_sb_en  = $urandom_range(0, 1) == 1;
        clk_gate_en = $urandom_range(0, 9) != 0;
        wake_cycles = DW'($urandom);
      end
      scan_req  = $urandom_range(0, 99) < 25;
      scan_done = $urandom_range(0, 99) < 15;
      scan_busy = $urandom_range(0, 99) < 10;
    end
    @(negedge clk);
    summary();
  end
endmodule